// File: doc/BRIEF.md
# Presettable Binary Down Counter

An eight-bit synchronous down counter with active-low controls. On each rising clock edge with counting enabled the count drops by one. A zero count wraps to all-ones, so one full cycle takes 256 clocks. A clear input drives the count to full scale at once. A level-sensitive preset override presents a jam word immediately. A synchronous preset loads the jam word at the next edge.

The active-low zero flag is the registered zero state gated by the enable input. It serves as the carry into a following stage. Stages that share one clock and chain flag to enable form a wider counter. Two stages give 65536 states.

Top module: `down_counter8`

## Requirements
- R1: While `clr_n` is low, `count` is 255 at once, without waiting for a clock, whatever every other input does. Clear wins over every other control.
- R2: While `clr_n` is high and `force_n` is low, `count` equals `jam` at once, whatever `load_n`, `ci_n` or the clock do. At each rising edge in this state the register takes `jam`, so the count keeps that value after release.
- R3: With `clr_n` and `force_n` high and `load_n` low, `jam` is loaded at the next rising edge, whether `ci_n` is high or low.
- R4: With all presets and clear inactive and `ci_n` low, the count decreases by one at each rising edge.
- R5: With all presets and clear inactive and `ci_n` high, the count holds.
- R6: `zero_n` is low exactly when `count` is 0 and `ci_n` is low. Otherwise it is high.
- R7: A count of 0 with counting enabled and no control active becomes 255 at the next edge, giving a 256-clock cycle.
- R8: Two stages on one clock, with the low stage's `zero_n` driving the high stage's `ci_n`, step together as one 16-bit down counter. A combined count of 0 wraps to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| ci_n | input | 1 | Count enable / carry in, active low |
| load_n | input | 1 | Synchronous preset, active low |
| force_n | input | 1 | Asynchronous preset override, active low |
| clr_n | input | 1 | Asynchronous clear to full scale, active low |
| jam | input | WIDTH | Preset word |
| count | output | WIDTH | Current count |
| zero_n | output | 1 | Zero detect / carry out, active low |

## Verification
The clocked properties treat `clr_n` as the reset and are disabled while it is low. They assume that `jam` stays stable while `force_n` is held low across a rising edge. They also assume that no control changes right at a rising edge. The stimulus changes every input only at the falling edge. It holds each preset through at least one rising edge, and it keeps `jam` fixed whenever the override is released. The immediate effects of clear and the override are sampled before the next rising edge, so they are seen as asynchronous and not as clocked.

// File: rtl/down_counter8.sv
module down_counter8 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             ci_n,
  input  logic             load_n,
  input  logic             force_n,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] jam,
  output logic [WIDTH-1:0] count,
  output logic             zero_n
);
  localparam logic [WIDTH-1:0] FULL = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)                 cnt_q <= FULL;
    else if (!force_n || !load_n) cnt_q <= jam;
    else if (!ci_n)             cnt_q <= cnt_q - ONE;

  assign count  = !clr_n ? FULL : (!force_n ? jam : cnt_q);
  assign zero_n = !((count == '0) && !ci_n);

  assert_force_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !force_n |=> cnt_q == $past(jam));
  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (force_n && !load_n) |=> cnt_q == $past(jam));
  assert_dec_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (force_n && load_n && !ci_n) |=> cnt_q == $past(cnt_q) - ONE);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (force_n && load_n && ci_n) |=> $stable(cnt_q));
  assert_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
    !zero_n |-> (!ci_n && count == '0));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (!zero_n && force_n && load_n) |=> cnt_q == FULL);
endmodule

// File: tb/down_counter8_test.sv
`timescale 1ns/1ps
module down_counter8_test;
  logic clk = 1'b0;
  logic ci_n = 1'b1, load_n = 1'b1, force_n = 1'b1, clr_n = 1'b0;
  logic [7:0] jam = 8'h00, jam_hi = 8'h00;
  logic [7:0] count, count_hi;
  logic zero_n, zero_hi_n;

  always #2.5 clk = ~clk;

  down_counter8 #(.WIDTH(8)) uut (
    .clk(clk), .ci_n(ci_n), .load_n(load_n), .force_n(force_n), .clr_n(clr_n),
    .jam(jam), .count(count), .zero_n(zero_n));

  down_counter8 #(.WIDTH(8)) uut_hi (
    .clk(clk), .ci_n(zero_n), .load_n(load_n), .force_n(force_n), .clr_n(clr_n),
    .jam(jam_hi), .count(count_hi), .zero_n(zero_hi_n));

  typedef struct packed {
    logic [7:0] lo; logic zlo; logic [7:0] hi; logic zhi; logic [7:0] req;
  } exp_t;
  exp_t q[$];

  int tests = 0, fails = 0;
  logic [7:0] m_lo = 8'hFF, m_hi = 8'hFF;
  bit done = 0;

  task automatic step(input logic ci, input logic ld, input logic fc, input logic cl,
                      input logic [7:0] j, input logic [7:0] jh, input int req);
    exp_t e;
    logic [7:0] vlo, vhi, nlo, nhi;
    logic zl, zh;
    @(negedge clk);
    ci_n = ci; load_n = ld; force_n = fc; clr_n = cl; jam = j; jam_hi = jh;
    if (!cl) begin m_lo = 8'hFF; m_hi = 8'hFF; end
    vlo = !cl ? 8'hFF : (!fc ? j : m_lo);
    vhi = !cl ? 8'hFF : (!fc ? jh : m_hi);
    zl  = !((vlo == 8'h00) && !ci);
    zh  = !((vhi == 8'h00) && !zl);
    e.lo = vlo; e.zlo = zl; e.hi = vhi; e.zhi = zh; e.req = 8'(req);
    q.push_back(e);
    nlo = m_lo; nhi = m_hi;
    if (!cl) begin nlo = 8'hFF; nhi = 8'hFF; end
    else if (!fc || !ld) begin nlo = j; nhi = jh; end
    else begin
      if (!ci) nlo = m_lo - 8'd1;
      if (!zl) nhi = m_hi - 8'd1;
    end
    @(posedge clk);
    m_lo = nlo; m_hi = nhi;
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (count !== e.lo || zero_n !== e.zlo || count_hi !== e.hi || zero_hi_n !== e.zhi) begin
          fails++;
          $display("FAIL R%0d: got lo=%h z=%b hi=%h zh=%b, expected lo=%h z=%b hi=%h zh=%b",
                   e.req, count, zero_n, count_hi, zero_hi_n, e.lo, e.zlo, e.hi, e.zhi);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h11, 1);  // R1 clear wins over all
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1);  // R1
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 5);  // R5 hold at full
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 5);  // R5
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h05, 8'h00, 3);  // R3 load while disabled
    for (int i = 0; i < 8; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 4); // R4 R6 R7 down through zero and wrap
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h02, 3);  // R3 load while enabled
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 6);  // R6 zero but disabled: flag high
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 6);  // R6 zero and enabled: flag low, R7 wrap next
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 7);  // R7
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h40, 2);  // R2 override beats sync preset and enable
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 8'h40, 2);  // R2
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 8'h40, 2);  // R2 value kept after release
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h12, 8'h34, 1);  // R1 clear beats override
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h12, 8'h34, 1);  // R1
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h02, 8'h01, 8);  // R8 cascade load 0x0102
    for (int i = 0; i < 300; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8); // R8 borrow into high stage
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h00, 8);  // R8 load 0x0001
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8); // R8 combined wrap to 0xFFFF
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 5);  // R5 both stages hold
    @(negedge clk); #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule